// File: doc/BRIEF.md
# Dual-Threshold Hit Channel Buffer

This block serves one detector channel that is watched by two discriminators, one set high and one set low. A single 32-bit word stream reaches it from the time-to-digital converter. Coarse timestamp words and fine hit words arrive interleaved in that stream. The block keeps the most recent coarse timestamp. It joins each hit to that timestamp to form a 40-bit hit time, then writes the time into the buffer for the threshold the hit belongs to. The high-threshold buffer is smaller than the low-threshold buffer.

Each buffer is drained by its own output controller. The downstream event finder raises a per-path ready signal. Whenever ready is high and the buffer holds data, one time word leaves that path with a one-cycle valid strobe. Hits that arrive before any timestamp has been seen are thrown away. A hit that finds its buffer full is also thrown away, and a sticky per-path overflow flag records the loss.

Top module: `thb_channel`

## Requirements
- R1: While reset is high and on the first cycle after it, both empty flags read 1, both valid strobes read 0 and both overflow flags read 0.
- R2: A hit word accepted before the first timestamp word since reset is discarded and never reaches either output.
- R3: Bit 31 of an input word set to 1 marks a timestamp word, and its bits [17:0] are kept. Bit 31 set to 0 marks a hit word whose fine field is bits [21:0]. The time produced is {kept timestamp bits, fine field}, 40 bits. Bits [29:22] of any word have no effect.
- R4: Each hit takes the timestamp from the latest timestamp word accepted before it.
- R5: Bit 30 of a hit word picks the path: 1 sends the time to the high output, 0 to the low output. Each path delivers its times in arrival order.
- R6: The high path holds 8 times. While it is full, further high hits are dropped and the 8 stored times are delivered unchanged.
- R7: The low path holds 16 times without loss. A 17th unread low hit is dropped.
- R8: A path's overflow flag goes to 1 when a hit for that path is dropped for lack of space. It stays at 1 until reset and is unaffected by the other path.
- R9: With ready high and the path empty, a hit's time appears with valid high after the second rising edge following the edge that samples the hit word.
- R10: A path emits at most one word per cycle, each with valid high for one cycle. It emits nothing while its ready is low.
- R11: A word presented while in_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 32 | Timestamp or hit word |
| hi_ready | input | 1 | Downstream accepts a high-path word |
| hi_valid | output | 1 | High-path word strobe |
| hi_time | output | 40 | High-path hit time |
| hi_empty | output | 1 | High buffer holds nothing |
| hi_ovf | output | 1 | Sticky high-path drop flag |
| lo_ready | input | 1 | Downstream accepts a low-path word |
| lo_valid | output | 1 | Low-path word strobe |
| lo_time | output | 40 | Low-path hit time |
| lo_empty | output | 1 | Low buffer holds nothing |
| lo_ovf | output | 1 | Sticky low-path drop flag |

## Verification
A hit word is captured into the push register on edge E0 and written into its buffer on E1. It is read out on E2 and is visible with valid after E2, so the latency check samples the falling edges after E0, E1, E2 and E3 and expects valid only at the third. Overflow and empty flags are sampled three cycles after the last driven word, when the final write has settled. Ordering and content checks do not depend on timing: a collector stores every strobed word shortly before each falling edge, and the stored words are compared with bench-computed expectations once the stream has drained.

// File: rtl/thb_pkg.sv
package thb_pkg;
  localparam int WORD_W   = 32;
  localparam int FINE_W   = 22;
  localparam int TIME_W   = 40;
  localparam int STAMP_W  = TIME_W - FINE_W;
  localparam int KIND_BIT = WORD_W - 1;
  localparam int PATH_BIT = WORD_W - 2;

  typedef struct packed {
    logic              valid;
    logic              hi;
    logic [TIME_W-1:0] t;
  } hit_t;
endpackage

// File: rtl/thb_ingress.sv
module thb_ingress
  import thb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output hit_t              hit_o
);
  logic [STAMP_W-1:0] stamp_q;
  logic               seen_q;
  hit_t               hit_q;
  logic               unused_bits;

  assign unused_bits = ^in_word[PATH_BIT-1:FINE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
      seen_q  <= 1'b0;
      hit_q   <= '0;
    end else begin
      hit_q.valid <= 1'b0;
      if (in_valid) begin
        if (in_word[KIND_BIT]) begin
          stamp_q <= in_word[STAMP_W-1:0];
          seen_q  <= 1'b1;
        end else if (seen_q) begin
          hit_q.valid <= 1'b1;
          hit_q.hi    <= in_word[PATH_BIT];
          hit_q.t     <= {stamp_q, in_word[FINE_W-1:0]};
        end
      end
    end
  end

  assign hit_o = hit_q;

  // R2
  stamp_before_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q.valid |-> seen_q);
  // R2
  seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |=> seen_q);
endmodule

// File: rtl/thb_fifo.sv
module thb_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rd_q;
  logic          ovf_q;
  logic          full, wr_en;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_en = wr_req && !full;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr_req && full) ovf_q <= 1'b1;
    end
  end

  assign rd_data = rd_q;
  assign ovf     = ovf_q;

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_en) |=> $stable(cnt));
  // R10
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/thb_drain.sv
module thb_drain (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic empty,
  output logic rd_en,
  output logic out_valid
);
  typedef enum logic {DR_IDLE = 1'b0, DR_SEND = 1'b1} dr_state_e;
  dr_state_e state;

  assign rd_en = ready && !empty;

  always_ff @(posedge clk) begin
    if (rst) state <= DR_IDLE;
    else     state <= rd_en ? DR_SEND : DR_IDLE;
  end

  assign out_valid = (state == DR_SEND);

  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !out_valid);
  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    empty |=> !out_valid);
endmodule

// File: rtl/thb_channel.sv
module thb_channel
  import thb_pkg::*;
#(
  parameter int HI_DEPTH = 8,
  parameter int LO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic        hi_ready,
  output logic        hi_valid,
  output logic [39:0] hi_time,
  output logic        hi_empty,
  output logic        hi_ovf,
  input  logic        lo_ready,
  output logic        lo_valid,
  output logic [39:0] lo_time,
  output logic        lo_empty,
  output logic        lo_ovf
);
  hit_t              hit;
  logic              rdy [2];
  logic              vld [2];
  logic              emp [2];
  logic              ovf [2];
  logic [TIME_W-1:0] dat [2];

  thb_ingress u_ingress (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  (in_word),
    .hit_o    (hit)
  );

  assign rdy[0] = lo_ready;
  assign rdy[1] = hi_ready;

  for (genvar g = 0; g < 2; g++) begin : g_path
    localparam int D = (g == 1) ? HI_DEPTH : LO_DEPTH;
    logic wr_req, rd_en;

    assign wr_req = hit.valid && (hit.hi == 1'(g));

    thb_fifo #(.DEPTH(D), .W(TIME_W)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_req  (wr_req),
      .wr_data (hit.t),
      .rd_en   (rd_en),
      .rd_data (dat[g]),
      .empty   (emp[g]),
      .ovf     (ovf[g])
    );

    thb_drain u_drain (
      .clk       (clk),
      .rst       (rst),
      .ready     (rdy[g]),
      .empty     (emp[g]),
      .rd_en     (rd_en),
      .out_valid (vld[g])
    );
  end

  assign hi_valid = vld[1];
  assign hi_time  = dat[1];
  assign hi_empty = emp[1];
  assign hi_ovf   = ovf[1];
  assign lo_valid = vld[0];
  assign lo_time  = dat[0];
  assign lo_empty = emp[0];
  assign lo_ovf   = ovf[0];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (hi_empty && lo_empty && !hi_valid && !lo_valid && !hi_ovf && !lo_ovf));
endmodule

// File: tb/tb_thb_channel.sv
module tb_thb_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        hi_ready = 1'b0, lo_ready = 1'b0;
  logic        hi_valid, lo_valid, hi_empty, lo_empty, hi_ovf, lo_ovf;
  logic [39:0] hi_time, lo_time;

  always #4 clk = ~clk;

  thb_channel dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .hi_ready(hi_ready), .hi_valid(hi_valid), .hi_time(hi_time),
    .hi_empty(hi_empty), .hi_ovf(hi_ovf),
    .lo_ready(lo_ready), .lo_valid(lo_valid), .lo_time(lo_time),
    .lo_empty(lo_empty), .lo_ovf(lo_ovf)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [39:0] got_hi[$], got_lo[$], exp_hi[$], exp_lo[$];

  always @(posedge clk) begin
    #3;
    if (!rst && hi_valid) got_hi.push_back(hi_time);
    if (!rst && lo_valid) got_lo.push_back(lo_time);
  end

  function automatic logic [31:0] ts_word(input logic [29:0] v);
    return {2'b10, v};
  endfunction
  function automatic logic [31:0] hit_word(input logic hi, input logic [21:0] f);
    return {1'b0, hi, 8'h00, f};
  endfunction
  function automatic logic [39:0] exp_time(input logic [31:0] ts, input logic [31:0] hw);
    return {ts[17:0], hw[21:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
  endtask

  task automatic quiet();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    cyc(3);
    chk(hi_empty && lo_empty && !hi_valid && !lo_valid && !hi_ovf && !lo_ovf,
        "R1 in reset", {hi_empty, lo_empty, hi_valid, lo_valid, hi_ovf, lo_ovf}, 6'b110000);
    rst = 1'b0;
    @(negedge clk);
    chk(hi_empty && lo_empty && !hi_valid && !lo_valid && !hi_ovf && !lo_ovf,
        "R1 after reset", {hi_empty, lo_empty, hi_valid, lo_valid, hi_ovf, lo_ovf}, 6'b110000);
    got_hi.delete(); got_lo.delete(); exp_hi.delete(); exp_lo.delete();
  endtask

  task automatic cmp_queues(input string rq);
    chk(got_hi.size() == exp_hi.size(), {rq, " high count"}, got_hi.size(), exp_hi.size());
    chk(got_lo.size() == exp_lo.size(), {rq, " low count"}, got_lo.size(), exp_lo.size());
    for (int i = 0; i < exp_hi.size() && i < got_hi.size(); i++)
      chk(got_hi[i] == exp_hi[i], {rq, " high word"}, got_hi[i], exp_hi[i]);
    for (int i = 0; i < exp_lo.size() && i < got_lo.size(); i++)
      chk(got_lo[i] == exp_lo[i], {rq, " low word"}, got_lo[i], exp_lo[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1-run actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] m_ts, w;
    bit m_seen;
    void'($urandom(32'd4711));

    // R1, R9 latency
    do_reset();
    hi_ready = 1'b1; lo_ready = 1'b1;
    put(ts_word(30'd5));
    put(hit_word(1'b1, 22'h1ABCD));
    @(negedge clk); in_valid = 1'b0;
    chk(!hi_valid, "R9 after E0", hi_valid, 0);
    @(negedge clk);
    chk(!hi_valid, "R9 after E1", hi_valid, 0);
    @(negedge clk);
    chk(hi_valid, "R9 after E2", hi_valid, 1);
    chk(hi_time == {18'd5, 22'h1ABCD}, "R9 R3 data", hi_time, {18'd5, 22'h1ABCD});
    chk(!lo_valid, "R5 low untouched", lo_valid, 0);
    @(negedge clk);
    chk(!hi_valid, "R10 single strobe", hi_valid, 0);

    // R2 hits before any timestamp
    do_reset();
    put(hit_word(1'b1, 22'h11));
    put(hit_word(1'b0, 22'h22));
    quiet(); cyc(6);
    chk(got_hi.size() == 0 && got_lo.size() == 0, "R2 no output", got_hi.size() + got_lo.size(), 0);
    chk(hi_empty && lo_empty, "R2 empty", {hi_empty, lo_empty}, 2'b11);

    // R4 latest timestamp, R3 ignored bits
    put(ts_word(30'd7));
    put(ts_word({8'hFF, 22'd9}));
    put({1'b0, 1'b0, 8'hA5, 22'h3});
    quiet(); cyc(6);
    exp_lo.push_back({18'd9, 22'h3});
    cmp_queues("R4");

    // R11 words with in_valid low
    got_lo.delete(); exp_lo.delete();
    @(negedge clk); in_valid = 1'b0; in_word = hit_word(1'b0, 22'h77);
    @(negedge clk); in_word = ts_word(30'd1);
    @(negedge clk); in_word = hit_word(1'b1, 22'h78);
    cyc(6);
    chk(got_hi.size() == 0 && got_lo.size() == 0, "R11 no output", got_hi.size() + got_lo.size(), 0);
    put(hit_word(1'b0, 22'h5));
    quiet(); cyc(6);
    exp_lo.push_back({18'd9, 22'h5});
    cmp_queues("R11 stamp kept");

    // R10 stall
    do_reset();
    hi_ready = 1'b1; lo_ready = 1'b0;
    put(ts_word(30'd1));
    for (int i = 0; i < 3; i++) put(hit_word(1'b0, 22'(i + 40)));
    quiet(); cyc(6);
    chk(got_lo.size() == 0, "R10 held while not ready", got_lo.size(), 0);
    chk(!lo_empty, "R10 data stored", lo_empty, 0);
    lo_ready = 1'b1;
    @(negedge clk);
    chk(lo_valid && lo_time == {18'd1, 22'd40}, "R10 one word", lo_time, {18'd1, 22'd40});
    lo_ready = 1'b0;
    @(negedge clk);
    chk(!lo_valid, "R10 stop", lo_valid, 0);
    cyc(3);
    chk(got_lo.size() == 1, "R10 stays stopped", got_lo.size(), 1);
    lo_ready = 1'b1; cyc(6);
    for (int i = 0; i < 3; i++) exp_lo.push_back({18'd1, 22'(i + 40)});
    cmp_queues("R10 R5 order");

    // R6 R8 high overflow
    do_reset();
    hi_ready = 1'b0; lo_ready = 1'b1;
    put(ts_word(30'd2));
    for (int i = 0; i < 10; i++) put(hit_word(1'b1, 22'(i)));
    quiet(); cyc(3);
    chk(hi_ovf, "R8 high flag", hi_ovf, 1);
    chk(!lo_ovf, "R8 low untouched", lo_ovf, 0);
    hi_ready = 1'b1; cyc(14);
    for (int i = 0; i < 8; i++) exp_hi.push_back({18'd2, 22'(i)});
    cmp_queues("R6");
    chk(hi_ovf && hi_empty, "R8 sticky after drain", {hi_ovf, hi_empty}, 2'b11);

    // R7 low capacity
    lo_ready = 1'b0;
    got_hi.delete(); exp_hi.delete();
    for (int i = 0; i < 16; i++) put(hit_word(1'b0, 22'(i + 100)));
    quiet(); cyc(3);
    chk(!lo_ovf, "R7 sixteen fit", lo_ovf, 0);
    put(hit_word(1'b0, 22'd999));
    quiet(); cyc(3);
    chk(lo_ovf, "R7 seventeenth dropped", lo_ovf, 1);
    lo_ready = 1'b1; cyc(22);
    for (int i = 0; i < 16; i++) exp_lo.push_back({18'd2, 22'(i + 100)});
    cmp_queues("R7");
    do_reset();
    chk(!hi_ovf && !lo_ovf, "R8 cleared by reset", {hi_ovf, lo_ovf}, 0);

    // Random stream, R3 R4 R5 R2
    hi_ready = 1'b1; lo_ready = 1'b1;
    m_seen = 1'b0; m_ts = '0;
    for (int n = 0; n < 400; n++) begin
      w = $urandom();
      w[31] = ($urandom_range(3) == 0);
      @(negedge clk);
      in_valid = ($urandom_range(3) != 0);
      in_word  = w;
      if (in_valid) begin
        if (w[31]) begin
          m_ts = w; m_seen = 1'b1;
        end else if (m_seen) begin
          if (w[30]) exp_hi.push_back(exp_time(m_ts, w));
          else       exp_lo.push_back(exp_time(m_ts, w));
        end
      end
    end
    quiet(); cyc(10);
    cmp_queues("R3 R5 random");
    chk(!hi_ovf && !lo_ovf, "R8 no drops", {hi_ovf, lo_ovf}, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule